// File: doc/BRIEF.md
# Reset Boot Entry Selector

After every reset this block decides where the processor starts and whether the boot area is mapped into code space. It samples three inputs once: an active-low in-system-programming request pin, a bootloader-jump fuse bit (0 means programmed), and an 8-bit software boot vector. The decision is made in two stages. The hardware stage sets the boot-mapping flag, the reset start address and a flash control marker. The software stage reads that marker and the boot vector, and picks the user application, a user bootloader, or the built-in bootloader.

The final entry address and a one-cycle done strobe come out on the third clock edge after reset is released. All results then hold until the next reset, whatever the inputs do.

Top module: `boot_entry_sel`

## Requirements
- R1: While reset is asserted, boot_map_en is 0, start_addr is 0000h, flash_ctl is 00h, entry_addr is 0000h, entry_kind is 0 (application) and done is 0.
- R2: If isp_n is low at the sampling edge, the hardware stage gives boot_map_en=1, start_addr=F000h and flash_ctl=00h. These values are visible after the second clock edge following reset release.
- R3: If isp_n is high and jump_fuse_n is 0 (programmed), the hardware stage gives boot_map_en=1, start_addr=F000h and flash_ctl=F0h.
- R4: If isp_n and jump_fuse_n are both high, the hardware stage gives boot_map_en=0, start_addr=0000h and flash_ctl=F0h. The final selection is then entry_kind=0 (application) with entry_addr=0000h.
- R5: When the boot area is mapped and flash_ctl is 00h, the final selection is entry_kind=2 (built-in bootloader) with entry_addr=F000h, whatever the boot vector is.
- R6: When the boot area is mapped, flash_ctl is nonzero and boot_vec is below F0h, the final selection is entry_kind=1 (user bootloader). entry_addr then has boot_vec as its high byte and 00h as its low byte.
- R7: When the boot area is mapped, flash_ctl is nonzero and boot_vec is F0h or above, the final selection is entry_kind=2 with entry_addr=F000h.
- R8: isp_n, jump_fuse_n and boot_vec are sampled only on the first clock edge after reset release. Changes after that edge have no effect, and every output holds once done has fired.
- R9: done is high for exactly one cycle, following the third clock edge after reset release, and stays low after that until the next reset.
- R10: A low isp_n takes priority over a programmed jump fuse.
- R11: Whenever the built-in bootloader is selected, entry_addr lies in the mapped boot window F000h to FFFFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| isp_n | input | 1 | Active-low programming request pin |
| jump_fuse_n | input | 1 | Bootloader-jump fuse, 0 = programmed |
| boot_vec | input | 8 | Software boot vector byte |
| boot_map_en | output | 1 | Boot area mapped into code space |
| start_addr | output | 16 | Reset start address from the hardware stage |
| flash_ctl | output | 8 | Flash control marker from the hardware stage |
| entry_addr | output | 16 | Final entry address |
| entry_kind | output | 2 | 0 application, 1 user bootloader, 2 built-in bootloader |
| done | output | 1 | One-cycle strobe when the selection is final |

## Verification
The assertions assume that the hardware and software stage results move only on their enable pulses. They also assume that reset is held long enough for the sequencer to restart from its sampling state. The assertions relate the latched pin value to the hardware-stage outputs, and the final selection to the flash marker and the boot vector. The bench holds the inputs steady across the sampling edge and scrambles them right after it. This exercises R8 without ever changing an input on the sampling edge itself.

// File: rtl/boot_sel_pkg.sv
package boot_sel_pkg;
  localparam int ADDR_W = 16;
  localparam int VEC_W  = 8;
  localparam int CTL_W  = 8;
  localparam int LOW_W  = ADDR_W - VEC_W;

  typedef enum logic [1:0] {
    ENTRY_APP  = 2'd0,
    ENTRY_USER = 2'd1,
    ENTRY_ROM  = 2'd2
  } entry_kind_e;

  typedef enum logic [1:0] {
    SEQ_SAMPLE = 2'd0,
    SEQ_HW     = 2'd1,
    SEQ_SW     = 2'd2,
    SEQ_HOLD   = 2'd3
  } seq_state_e;

  typedef struct packed {
    logic              map_en;
    logic [ADDR_W-1:0] start;
    logic [CTL_W-1:0]  fctl;
  } hw_result_t;

  typedef struct packed {
    entry_kind_e       kind;
    logic [ADDR_W-1:0] addr;
  } sw_result_t;

  // Hardware stage: the pin wins over the fuse.
  function automatic hw_result_t hw_decide(
    input logic              pin_req,
    input logic              fuse_prog,
    input logic [ADDR_W-1:0] boot_base,
    input logic [CTL_W-1:0]  pin_mark,
    input logic [CTL_W-1:0]  norm_mark
  );
    hw_result_t r;
    if (pin_req) begin
      r.map_en = 1'b1;
      r.start  = boot_base;
      r.fctl   = pin_mark;
    end else if (fuse_prog) begin
      r.map_en = 1'b1;
      r.start  = boot_base;
      r.fctl   = norm_mark;
    end else begin
      r.map_en = 1'b0;
      r.start  = '0;
      r.fctl   = norm_mark;
    end
    return r;
  endfunction

  // Software stage: the marker and the vector pick the entry point.
  function automatic sw_result_t sw_decide(
    input hw_result_t        hw,
    input logic [VEC_W-1:0]  vec,
    input logic [VEC_W-1:0]  vec_limit,
    input logic [ADDR_W-1:0] boot_base,
    input logic [CTL_W-1:0]  pin_mark
  );
    sw_result_t r;
    if (!hw.map_en) begin
      r.kind = ENTRY_APP;
      r.addr = hw.start;
    end else if (hw.fctl == pin_mark) begin
      r.kind = ENTRY_ROM;
      r.addr = boot_base;
    end else if (vec < vec_limit) begin
      r.kind = ENTRY_USER;
      r.addr = {vec, {LOW_W{1'b0}}};
    end else begin
      r.kind = ENTRY_ROM;
      r.addr = boot_base;
    end
    return r;
  endfunction
endpackage

// File: rtl/boot_seq_ctrl.sv
module boot_seq_ctrl
  import boot_sel_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  output logic sample_fire,
  output logic hw_fire,
  output logic sw_fire
);
  seq_state_e state_q;

  assign sample_fire = (state_q == SEQ_SAMPLE);
  assign hw_fire     = (state_q == SEQ_HW);
  assign sw_fire     = (state_q == SEQ_SW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_SAMPLE;
    end else begin
      unique case (state_q)
        SEQ_SAMPLE: state_q <= SEQ_HW;
        SEQ_HW:     state_q <= SEQ_SW;
        SEQ_SW:     state_q <= SEQ_HOLD;
        default:    state_q <= SEQ_HOLD;
      endcase
    end
  end
endmodule

// File: rtl/boot_input_latch.sv
module boot_input_latch
  import boot_sel_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_fire,
  input  logic             isp_n,
  input  logic             jump_fuse_n,
  input  logic [VEC_W-1:0] boot_vec,
  output logic             isp_q,
  output logic             fuse_q,
  output logic [VEC_W-1:0] vec_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isp_q  <= 1'b1;
      fuse_q <= 1'b1;
      vec_q  <= '1;
    end else if (sample_fire) begin
      isp_q  <= isp_n;
      fuse_q <= jump_fuse_n;
      vec_q  <= boot_vec;
    end
  end
endmodule

// File: rtl/boot_hw_stage.sv
module boot_hw_stage
  import boot_sel_pkg::*;
#(
  parameter logic [ADDR_W-1:0] BOOT_BASE = 16'hF000,
  parameter logic [CTL_W-1:0]  PIN_MARK  = 8'h00,
  parameter logic [CTL_W-1:0]  NORM_MARK = 8'hF0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hw_fire,
  input  logic       isp_q,
  input  logic       fuse_q,
  output hw_result_t hw_q
);
  hw_result_t hw_d;

  always_comb hw_d = hw_decide(!isp_q, !fuse_q, BOOT_BASE, PIN_MARK, NORM_MARK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hw_q <= '0;
    else if (hw_fire) hw_q <= hw_d;
  end
endmodule

// File: rtl/boot_sw_stage.sv
module boot_sw_stage
  import boot_sel_pkg::*;
#(
  parameter logic [ADDR_W-1:0] BOOT_BASE = 16'hF000,
  parameter logic [CTL_W-1:0]  PIN_MARK  = 8'h00,
  parameter logic [VEC_W-1:0]  VEC_LIMIT = 8'hF0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_fire,
  input  hw_result_t       hw_q,
  input  logic [VEC_W-1:0] vec_q,
  output sw_result_t       sw_q,
  output logic             done_q
);
  sw_result_t sw_d;

  always_comb sw_d = sw_decide(hw_q, vec_q, VEC_LIMIT, BOOT_BASE, PIN_MARK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_q   <= '{kind: ENTRY_APP, addr: '0};
      done_q <= 1'b0;
    end else begin
      done_q <= sw_fire;
      if (sw_fire) sw_q <= sw_d;
    end
  end
endmodule

// File: rtl/boot_entry_sel.sv
module boot_entry_sel
  import boot_sel_pkg::*;
#(
  parameter logic [ADDR_W-1:0] BOOT_BASE = 16'hF000,
  parameter logic [CTL_W-1:0]  PIN_MARK  = 8'h00,
  parameter logic [CTL_W-1:0]  NORM_MARK = 8'hF0,
  parameter logic [VEC_W-1:0]  VEC_LIMIT = 8'hF0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              isp_n,
  input  logic              jump_fuse_n,
  input  logic [VEC_W-1:0]  boot_vec,
  output logic              boot_map_en,
  output logic [ADDR_W-1:0] start_addr,
  output logic [CTL_W-1:0]  flash_ctl,
  output logic [ADDR_W-1:0] entry_addr,
  output logic [1:0]        entry_kind,
  output logic              done
);
  logic             sample_fire, hw_fire, sw_fire;
  logic             isp_q, fuse_q;
  logic [VEC_W-1:0] vec_q;
  hw_result_t       hw_q;
  sw_result_t       sw_q;

  boot_seq_ctrl u_seq (
    .clk(clk), .rst_n(rst_n),
    .sample_fire(sample_fire), .hw_fire(hw_fire), .sw_fire(sw_fire)
  );

  boot_input_latch u_latch (
    .clk(clk), .rst_n(rst_n), .sample_fire(sample_fire),
    .isp_n(isp_n), .jump_fuse_n(jump_fuse_n), .boot_vec(boot_vec),
    .isp_q(isp_q), .fuse_q(fuse_q), .vec_q(vec_q)
  );

  boot_hw_stage #(
    .BOOT_BASE(BOOT_BASE), .PIN_MARK(PIN_MARK), .NORM_MARK(NORM_MARK)
  ) u_hw (
    .clk(clk), .rst_n(rst_n), .hw_fire(hw_fire),
    .isp_q(isp_q), .fuse_q(fuse_q), .hw_q(hw_q)
  );

  boot_sw_stage #(
    .BOOT_BASE(BOOT_BASE), .PIN_MARK(PIN_MARK), .VEC_LIMIT(VEC_LIMIT)
  ) u_sw (
    .clk(clk), .rst_n(rst_n), .sw_fire(sw_fire),
    .hw_q(hw_q), .vec_q(vec_q), .sw_q(sw_q), .done_q(done)
  );

  assign boot_map_en = hw_q.map_en;
  assign start_addr  = hw_q.start;
  assign flash_ctl   = hw_q.fctl;
  assign entry_addr  = sw_q.addr;
  assign entry_kind  = sw_q.kind;
endmodule

// File: rtl/boot_entry_sel_chk.sv
module boot_entry_sel_chk
  import boot_sel_pkg::*;
#(
  parameter logic [ADDR_W-1:0] BOOT_BASE = 16'hF000,
  parameter logic [CTL_W-1:0]  PIN_MARK  = 8'h00,
  parameter logic [VEC_W-1:0]  VEC_LIMIT = 8'hF0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hw_fire,
  input logic              sw_fire,
  input logic              isp_q,
  input logic              boot_map_en,
  input logic [ADDR_W-1:0] start_addr,
  input logic [CTL_W-1:0]  flash_ctl,
  input logic [ADDR_W-1:0] entry_addr,
  input logic [1:0]        entry_kind,
  input logic              done
);
  logic fired_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    fired_q <= 1'b0;
    else if (done) fired_q <= 1'b1;
  end

  // R2
  isp_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hw_fire && !isp_q |=> boot_map_en && start_addr == BOOT_BASE && flash_ctl == PIN_MARK);

  // R4
  app_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !boot_map_en |-> entry_kind == 2'(ENTRY_APP) && entry_addr == '0);

  // R5
  pin_rom_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && boot_map_en && flash_ctl == PIN_MARK |-> entry_kind == 2'(ENTRY_ROM));

  // R6
  user_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && entry_kind == 2'(ENTRY_USER) |->
      entry_addr[LOW_W-1:0] == '0 && entry_addr[ADDR_W-1 -: VEC_W] < VEC_LIMIT
      && boot_map_en && flash_ctl != PIN_MARK);

  // R9
  done_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_fire |=> done);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  hold_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fired_q |=> $stable(entry_addr) && $stable(boot_map_en) && $stable(flash_ctl)
      && $stable(start_addr) && !done);

  // R11
  rom_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && entry_kind == 2'(ENTRY_ROM) |-> entry_addr >= BOOT_BASE);
endmodule

bind boot_entry_sel boot_entry_sel_chk #(
  .BOOT_BASE(BOOT_BASE), .PIN_MARK(PIN_MARK), .VEC_LIMIT(VEC_LIMIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .hw_fire(hw_fire), .sw_fire(sw_fire), .isp_q(isp_q),
  .boot_map_en(boot_map_en), .start_addr(start_addr), .flash_ctl(flash_ctl),
  .entry_addr(entry_addr), .entry_kind(entry_kind), .done(done)
);

// File: tb/tb_boot_entry_sel.sv
module tb_boot_entry_sel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        isp_n = 1'b1;
  logic        jump_fuse_n = 1'b1;
  logic [7:0]  boot_vec = 8'h00;
  logic        boot_map_en;
  logic [15:0] start_addr;
  logic [7:0]  flash_ctl;
  logic [15:0] entry_addr;
  logic [1:0]  entry_kind;
  logic        done;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  typedef struct {
    logic        map;
    logic [15:0] start;
    logic [7:0]  fctl;
    logic [1:0]  kind;
    logic [15:0] addr;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  exp_t cur;

  always #2.5 clk = ~clk;

  boot_entry_sel dut (
    .clk(clk), .rst_n(rst_n), .isp_n(isp_n), .jump_fuse_n(jump_fuse_n),
    .boot_vec(boot_vec), .boot_map_en(boot_map_en), .start_addr(start_addr),
    .flash_ctl(flash_ctl), .entry_addr(entry_addr), .entry_kind(entry_kind),
    .done(done)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected outcome, written as a table lookup on the pin, fuse and vector.
  function automatic exp_t model(input logic pin, input logic fuse, input logic [7:0] v, input string tag);
    exp_t e;
    e.tag = tag;
    case ({pin, fuse})
      2'b00, 2'b01: begin e.map = 1; e.start = 16'hF000; e.fctl = 8'h00; e.kind = 2; e.addr = 16'hF000; end
      2'b10: begin
        e.map = 1; e.start = 16'hF000; e.fctl = 8'hF0;
        if (v[7:4] != 4'hF) begin e.kind = 1; e.addr = {v, 8'h00}; end
        else begin e.kind = 2; e.addr = 16'hF000; end
      end
      default: begin e.map = 0; e.start = 16'h0000; e.fctl = 8'hF0; e.kind = 0; e.addr = 16'h0000; end
    endcase
    return e;
  endfunction

  // Monitor: compares each done strobe against the oldest expectation.
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        check("R9 unexpected done", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check({e.tag, " entry_kind"}, 32'(entry_kind), 32'(e.kind));
        check({e.tag, " entry_addr"}, 32'(entry_addr), 32'(e.addr));
      end
    end
  end

  task automatic run_case(input logic pin, input logic fuse, input logic [7:0] v, input string tag);
    cur = model(pin, fuse, v, tag);
    @(negedge clk);
    rst_n = 1'b0;
    isp_n = pin; jump_fuse_n = fuse; boot_vec = v;
    repeat (2) @(negedge clk);
    check("R1 map_en", 32'(boot_map_en), 0);
    check("R1 start", 32'(start_addr), 0);
    check("R1 fctl", 32'(flash_ctl), 0);
    check("R1 entry", 32'(entry_addr), 0);
    check("R1 kind", 32'(entry_kind), 0);
    check("R1 done", 32'(done), 0);
    exp_q.push_back(cur);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    // R8: scramble the inputs right after the sampling edge
    isp_n = ~pin; jump_fuse_n = ~fuse; boot_vec = ~v;
    @(posedge clk);
    @(negedge clk);
    check({tag, " R2/R3/R4 map_en"}, 32'(boot_map_en), 32'(cur.map));
    check({tag, " R2/R3/R4 start"}, 32'(start_addr), 32'(cur.start));
    check({tag, " R2/R3/R4 fctl"}, 32'(flash_ctl), 32'(cur.fctl));
    check("R9 done early", 32'(done), 0);
    @(negedge clk);
    check("R9 done strobe", 32'(done), 1);
    repeat (3) @(negedge clk);
    check("R9 done single", 32'(done), 0);
    check({tag, " R8 hold addr"}, 32'(entry_addr), 32'(cur.addr));
    check({tag, " R8 hold fctl"}, 32'(flash_ctl), 32'(cur.fctl));
    check("R9 queue drained", 32'(exp_q.size()), 0);
  endtask

  initial begin
    run_case(1'b0, 1'b0, 8'h12, "R10 pin+fuse R5");
    run_case(1'b0, 1'b1, 8'h00, "R2 pin only R5");
    run_case(1'b1, 1'b0, 8'h12, "R3 user R6");
    run_case(1'b1, 1'b0, 8'hEF, "R6 vec EF");
    run_case(1'b1, 1'b0, 8'h00, "R6 vec 00");
    run_case(1'b1, 1'b0, 8'hF0, "R7 vec F0 R11");
    run_case(1'b1, 1'b0, 8'hFF, "R7 vec FF R11");
    run_case(1'b1, 1'b1, 8'h12, "R4 app");
    run_case(1'b1, 1'b1, 8'hF5, "R4 app high vec");
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule